// File: doc/BRIEF.md
# Operand Addressing Mode Unit

This unit turns the operand fields of an instruction into something the datapath can use directly. It holds a bank of sixteen 16-bit working registers. For each operand it looks at a 3-bit mode, a register index, a second base-register index and the operand size. It then reports one of three results: the operand is a working register, the operand is the status register, or the operand sits in data memory at a computed effective address. Modes that step a pointer also write the stepped value back into the working register at the clock edge that ends the resolving cycle.

A single cycle resolves one operand. `req` marks a cycle that carries one. The result outputs are combinational from the current register contents and the request fields. A separate load port lets the datapath write results into the working registers. A read port lets any register be observed. A decode-variant input selects the encoding used by the offset-capable operand field, in which both upper mode codes mean register-plus-register.

Top module: `opnd_addr_unit`

## Requirements
- R1: After reset every working register reads 0 on `rd_data`, and with `req` low no operand flag is raised.
- R2: Mode 000 raises `op_regdir` with `op_reg` equal to `sel` and `op_ea` 0. It raises no memory flag and leaves every register unchanged.
- R3: Mode 001 raises `op_mem` with `op_ea` equal to the selected register. The register is not changed.
- R4: Modes 010 (post-decrement) and 011 (post-increment) raise `op_mem` with `op_ea` equal to the old register value. The register then becomes the old value minus (010) or plus (011) the step.
- R5: Modes 100 (pre-decrement) and 101 (pre-increment) raise `op_mem` with `op_ea` equal to the old value minus (100) or plus (101) the step. The register takes that same value.
- R6: Mode 110 with `alt_decode` low raises `op_sr` with `op_ea` 0, raises no memory flag and changes no register.
- R7: Mode 111 raises `op_mem` with `op_ea` equal to register `sel` plus register `base_sel`, modulo 2^16. Neither register is changed.
- R8: The step is 4 when `long_op` is 1, whatever `byte_op` is. Otherwise it is 1 when `byte_op` is 1 and 2 when both are 0. All pointer arithmetic wraps modulo 2^16.
- R9: With `alt_decode` high, modes 110 and 111 both behave as mode 111. The other codes are unchanged.
- R10: A pointer update shows on `rd_data` from the cycle after the resolving cycle. During the resolving cycle, `rd_data` for that register still shows the old value.
- R11: `wr_en` writes `wr_data` into register `wr_sel` at the clock edge. When it targets the same register as a pointer update in that cycle, the pointer update wins.
- R12: With `req` low, all operand flags, `op_reg` and `op_ea` are 0, and no pointer update occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Operand resolution request this cycle |
| mode | input | 3 | Addressing-mode code |
| alt_decode | input | 1 | Offset-field decode variant (11x = register offset) |
| sel | input | 4 | Working register index |
| base_sel | input | 4 | Base register index for register-offset mode |
| byte_op | input | 1 | Byte-size operand |
| long_op | input | 1 | 32-bit operand (overrides byte_op) |
| wr_en | input | 1 | Load port write enable |
| wr_sel | input | 4 | Load port register index |
| wr_data | input | 16 | Load port data |
| rd_sel | input | 4 | Observation read index |
| rd_data | output | 16 | Observation read data |
| op_regdir | output | 1 | Operand is a working register |
| op_mem | output | 1 | Operand is in data memory at op_ea |
| op_sr | output | 1 | Operand is the status register |
| op_reg | output | 4 | Register index for register-direct operands |
| op_ea | output | 16 | Effective data address |

## Verification
A wrong step size or a wrong increment direction does not show at once in every mode. Post-modify modes deliver the correct address in the resolving cycle and corrupt only the stored pointer. That fault appears on `rd_data` one cycle later, or on `op_ea` the next time the register is used. Pre-modify and offset errors appear at once on `op_ea`. A wrong priority between the two write sources appears on the cycle after the collision. The reference model is therefore compared on every cycle, including the read port, so that a stale or misstepped register is caught within one cycle of its update.

// File: rtl/oam_pkg.sv
package oam_pkg;
  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_REG  = 2'd1,
    KIND_MEM  = 2'd2,
    KIND_SR   = 2'd3
  } opnd_kind_e;

  typedef struct packed {
    opnd_kind_e kind;
    logic       upd;   // pointer register is written back
    logic       pre;   // modify before access
    logic       inc;   // step upward
    logic       ofs;   // register plus base register
  } mode_dec_t;

  localparam int unsigned STEP_BYTE = 1;
  localparam int unsigned STEP_WORD = 2;
  localparam int unsigned STEP_LONG = 4;
endpackage

// File: rtl/oam_decode.sv
module oam_decode
  import oam_pkg::*;
(
  input  logic       req,
  input  logic [2:0] mode,
  input  logic       alt_decode,
  output mode_dec_t  dec
);
  always_comb begin
    dec      = '0;
    dec.kind = KIND_NONE;
    if (req) begin
      unique case (mode)
        3'b000: dec.kind = KIND_REG;
        3'b001: dec.kind = KIND_MEM;
        3'b010, 3'b011, 3'b100, 3'b101: begin
          dec.kind = KIND_MEM;
          dec.upd  = 1'b1;
          dec.pre  = mode[2];
          dec.inc  = mode[0];
        end
        3'b110: begin
          if (alt_decode) begin
            dec.kind = KIND_MEM;
            dec.ofs  = 1'b1;
          end else begin
            dec.kind = KIND_SR;
          end
        end
        default: begin
          dec.kind = KIND_MEM;
          dec.ofs  = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/oam_agu.sv
module oam_agu
  import oam_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  mode_dec_t         dec,
  input  logic              byte_op,
  input  logic              long_op,
  input  logic [DATA_W-1:0] ptr,
  input  logic [DATA_W-1:0] base,
  output logic [DATA_W-1:0] ea,
  output logic [DATA_W-1:0] ptr_next
);
  logic [DATA_W-1:0] step;

  always_comb begin
    if (long_op)      step = DATA_W'(STEP_LONG);
    else if (byte_op) step = DATA_W'(STEP_BYTE);
    else              step = DATA_W'(STEP_WORD);
  end

  always_comb begin
    ptr_next = dec.inc ? (ptr + step) : (ptr - step);
    if (dec.kind != KIND_MEM) ea = '0;
    else if (dec.ofs)         ea = ptr + base;
    else if (dec.upd && dec.pre) ea = ptr_next;
    else                      ea = ptr;
  end
endmodule

// File: rtl/oam_regfile.sv
module oam_regfile #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NREG   = 16,
  localparam int unsigned SEL_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [SEL_W-1:0]  upd_sel,
  input  logic [DATA_W-1:0] upd_data,
  input  logic              ld_en,
  input  logic [SEL_W-1:0]  ld_sel,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [SEL_W-1:0]  ra_sel,
  output logic [DATA_W-1:0] ra_data,
  input  logic [SEL_W-1:0]  rb_sel,
  output logic [DATA_W-1:0] rb_data,
  input  logic [SEL_W-1:0]  rc_sel,
  output logic [DATA_W-1:0] rc_data
);
  logic [NREG-1:0][DATA_W-1:0] regs_q;
  logic [NREG-1:0][DATA_W-1:0] regs_d;
  logic [NREG-1:0]             regs_en;

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      regs_en[i] = 1'b0;
      regs_d[i]  = regs_q[i];
      if (upd_en && (upd_sel == SEL_W'(i))) begin
        regs_en[i] = 1'b1;
        regs_d[i]  = upd_data;
      end else if (ld_en && (ld_sel == SEL_W'(i))) begin
        regs_en[i] = 1'b1;
        regs_d[i]  = ld_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (regs_en[i]) regs_q[i] <= regs_d[i];
      end
    end
  end

  assign ra_data = regs_q[ra_sel];
  assign rb_data = regs_q[rb_sel];
  assign rc_data = regs_q[rc_sel];
endmodule

// File: rtl/opnd_addr_unit.sv
module opnd_addr_unit
  import oam_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NREG   = 16,
  localparam int unsigned SEL_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [2:0]        mode,
  input  logic              alt_decode,
  input  logic [SEL_W-1:0]  sel,
  input  logic [SEL_W-1:0]  base_sel,
  input  logic              byte_op,
  input  logic              long_op,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              op_regdir,
  output logic              op_mem,
  output logic              op_sr,
  output logic [SEL_W-1:0]  op_reg,
  output logic [DATA_W-1:0] op_ea
);
  logic [1:0]        rst_pipe_q;
  logic              rst_int_n;
  mode_dec_t         dec;
  logic [DATA_W-1:0] ptr_val;
  logic [DATA_W-1:0] base_val;
  logic [DATA_W-1:0] ptr_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  oam_decode u_dec (
    .req        (req),
    .mode       (mode),
    .alt_decode (alt_decode),
    .dec        (dec)
  );

  oam_agu #(.DATA_W(DATA_W)) u_agu (
    .dec      (dec),
    .byte_op  (byte_op),
    .long_op  (long_op),
    .ptr      (ptr_val),
    .base     (base_val),
    .ea       (op_ea),
    .ptr_next (ptr_next)
  );

  oam_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .upd_en   (dec.upd),
    .upd_sel  (sel),
    .upd_data (ptr_next),
    .ld_en    (wr_en),
    .ld_sel   (wr_sel),
    .ld_data  (wr_data),
    .ra_sel   (sel),
    .ra_data  (ptr_val),
    .rb_sel   (base_sel),
    .rb_data  (base_val),
    .rc_sel   (rd_sel),
    .rc_data  (rd_data)
  );

  assign op_regdir = (dec.kind == KIND_REG);
  assign op_mem    = (dec.kind == KIND_MEM);
  assign op_sr     = (dec.kind == KIND_SR);
  assign op_reg    = op_regdir ? sel : '0;
endmodule

// File: rtl/opnd_addr_unit_chk.sv
module opnd_addr_unit_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SEL_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic [2:0]        mode,
  input logic              alt_decode,
  input logic [SEL_W-1:0]  sel,
  input logic              byte_op,
  input logic              long_op,
  input logic              op_regdir,
  input logic              op_mem,
  input logic              op_sr,
  input logic [SEL_W-1:0]  op_reg,
  input logic [DATA_W-1:0] op_ea,
  input logic [DATA_W-1:0] ptr_val
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> (!op_regdir && !op_mem && !op_sr && op_ea == '0 && op_reg == '0)); // R12
  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> ($countones({op_regdir, op_mem, op_sr}) == 1)); // R9
  AST_REG_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (req && mode == 3'b000) |-> (op_regdir && op_reg == sel && op_ea == '0)); // R2
  AST_PLAIN_INDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (req && mode == 3'b001) |-> (op_mem && op_ea == ptr_val)); // R3
  AST_POST_OLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (req && mode[2:1] == 2'b01) |-> (op_mem && op_ea == ptr_val)); // R4
  AST_PRE_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (req && mode == 3'b101 && !byte_op && !long_op) |-> (op_ea == ptr_val + DATA_W'(2))); // R5
  AST_SR_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (req && mode == 3'b110 && !alt_decode) |-> (op_sr && !op_mem && op_ea == '0)); // R6
  AST_ALT_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (req && alt_decode && mode[2:1] == 2'b11) |-> op_mem); // R9
endmodule

bind opnd_addr_unit opnd_addr_unit_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req        (req),
  .mode       (mode),
  .alt_decode (alt_decode),
  .sel        (sel),
  .byte_op    (byte_op),
  .long_op    (long_op),
  .op_regdir  (op_regdir),
  .op_mem     (op_mem),
  .op_sr      (op_sr),
  .op_reg     (op_reg),
  .op_ea      (op_ea),
  .ptr_val    (ptr_val)
);

// File: tb/opnd_addr_unit_test.sv
module opnd_addr_unit_test;
  logic        clk;
  logic        rst_n;
  logic        req;
  logic [2:0]  mode;
  logic        alt_decode;
  logic [3:0]  sel;
  logic [3:0]  base_sel;
  logic        byte_op;
  logic        long_op;
  logic        wr_en;
  logic [3:0]  wr_sel;
  logic [15:0] wr_data;
  logic [3:0]  rd_sel;
  logic [15:0] rd_data;
  logic        op_regdir;
  logic        op_mem;
  logic        op_sr;
  logic [3:0]  op_reg;
  logic [15:0] op_ea;

  logic [15:0] mrf [16];
  int checks;
  int errors;

  opnd_addr_unit uut (
    .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .alt_decode(alt_decode),
    .sel(sel), .base_sel(base_sel), .byte_op(byte_op), .long_op(long_op),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .op_regdir(op_regdir), .op_mem(op_mem), .op_sr(op_sr),
    .op_reg(op_reg), .op_ea(op_ea)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string mode_tag(input bit r, input logic [2:0] m, input bit alt,
                                     input bit bo, input bit lo);
    if (!r) return "R12";
    if (alt && m[2:1] == 2'b11) return "R9";
    if ((m inside {3'd2, 3'd3, 3'd4, 3'd5}) && (bo || lo)) return "R8";
    case (m)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2, 3'd3: return "R4";
      3'd4, 3'd5: return "R5";
      3'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  // One cycle: drive, compare against the model, then advance the model.
  task automatic cyc(input bit r, input logic [2:0] m, input bit alt,
                     input logic [3:0] s, input logic [3:0] b, input bit bo,
                     input bit lo, input bit we, input logic [3:0] ws,
                     input logic [15:0] wd, input logic [3:0] rs, input string rtag);
    logic [2:0]  em;
    logic [15:0] step, old, nv, e_ea;
    bit e_reg, e_mem, e_sr, upd;
    string tag;
    @(negedge clk);
    req = r; mode = m; alt_decode = alt; sel = s; base_sel = b; byte_op = bo;
    long_op = lo; wr_en = we; wr_sel = ws; wr_data = wd; rd_sel = rs;
    #2;
    em   = (alt && m[2:1] == 2'b11) ? 3'd7 : m;
    step = lo ? 16'd4 : (bo ? 16'd1 : 16'd2);
    old  = mrf[s];
    nv   = em[0] ? old + step : old - step;
    e_reg = r && em == 3'd0;
    e_sr  = r && em == 3'd6;
    e_mem = r && !e_reg && !e_sr;
    upd   = r && (em inside {3'd2, 3'd3, 3'd4, 3'd5});
    e_ea  = 16'h0;
    if (e_mem) begin
      if (em == 3'd7) e_ea = old + mrf[b];
      else if (em == 3'd4 || em == 3'd5) e_ea = nv;
      else e_ea = old;
    end
    tag = mode_tag(r, m, alt, bo, lo);
    chk(op_regdir == e_reg, tag, "op_regdir", 16'(op_regdir), 16'(e_reg));
    chk(op_mem == e_mem, tag, "op_mem", 16'(op_mem), 16'(e_mem));
    chk(op_sr == e_sr, tag, "op_sr", 16'(op_sr), 16'(e_sr));
    chk(op_reg == (e_reg ? s : 4'd0), tag, "op_reg", 16'(op_reg), 16'(e_reg ? s : 4'd0));
    chk(op_ea == e_ea, tag, "op_ea", op_ea, e_ea);
    chk(rd_data == mrf[rs], rtag, "rd_data", rd_data, mrf[rs]);
    if (we) mrf[ws] = wd;         // R11: load port
    if (upd) mrf[s] = nv;         // R11: pointer update wins a collision
  endtask

  task automatic idle(input logic [3:0] rs, input string rtag);
    cyc(1'b0, 3'd0, 1'b0, 4'd0, 4'd0, 1'b0, 1'b0, 1'b0, 4'd0, 16'h0, rs, rtag);
  endtask

  task automatic load(input logic [3:0] ws, input logic [15:0] wd);
    cyc(1'b0, 3'd0, 1'b0, 4'd0, 4'd0, 1'b0, 1'b0, 1'b1, ws, wd, ws, "R11");
  endtask

  task automatic op(input logic [2:0] m, input bit alt, input logic [3:0] s,
                    input logic [3:0] b, input bit bo, input bit lo);
    cyc(1'b1, m, alt, s, b, bo, lo, 1'b0, 4'd0, 16'h0, s, "R10");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    for (int i = 0; i < 16; i++) mrf[i] = 16'h0;
    req = 0; mode = 0; alt_decode = 0; sel = 0; base_sel = 0; byte_op = 0;
    long_op = 0; wr_en = 0; wr_sel = 0; wr_data = 0; rd_sel = 0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    for (int i = 0; i < 16; i++) idle(4'(i), "R1");            // R1 reset contents
    for (int i = 0; i < 16; i++) load(4'(i), 16'h1000 + 16'(i) * 16'h0101);
    for (int i = 0; i < 16; i++) idle(4'(i), "R11");
    for (int m = 0; m < 8; m++) begin                         // every mode, word size
      op(3'(m), 1'b0, 4'd2, 4'd9, 1'b0, 1'b0);
      idle(4'd2, "R10");                                      // R10 update visible next cycle
    end
    for (int m = 2; m < 6; m++) begin                         // R8 byte and long steps
      op(3'(m), 1'b0, 4'd4, 4'd0, 1'b1, 1'b0);
      op(3'(m), 1'b0, 4'd4, 4'd0, 1'b0, 1'b1);
      op(3'(m), 1'b0, 4'd4, 4'd0, 1'b1, 1'b1);
      idle(4'd4, "R8");
    end
    load(4'd5, 16'hFFFF); op(3'd3, 1'b0, 4'd5, 4'd0, 1'b1, 1'b0); idle(4'd5, "R8");
    load(4'd6, 16'h0000); op(3'd4, 1'b0, 4'd6, 4'd0, 1'b0, 1'b0); idle(4'd6, "R8");
    load(4'd7, 16'hFFF0); load(4'd8, 16'h0020);
    op(3'd7, 1'b0, 4'd7, 4'd8, 1'b0, 1'b0);                   // R7 wrap
    idle(4'd7, "R7"); idle(4'd8, "R7");
    op(3'd6, 1'b1, 4'd7, 4'd8, 1'b0, 1'b0);                   // R9 alt decode
    op(3'd6, 1'b0, 4'd7, 4'd8, 1'b0, 1'b0);                   // R6 status register
    op(3'd1, 1'b1, 4'd7, 4'd8, 1'b0, 1'b0);
    idle(4'd7, "R6");
    // R11 collision: load and pointer update on the same register
    cyc(1'b1, 3'd3, 1'b0, 4'd3, 4'd0, 1'b0, 1'b0, 1'b1, 4'd3, 16'hBEEF, 4'd3, "R11");
    idle(4'd3, "R11");
    // Load and pointer update on different registers in one cycle
    cyc(1'b1, 3'd5, 1'b0, 4'd10, 4'd0, 1'b0, 1'b0, 1'b1, 4'd11, 16'h1234, 4'd10, "R11");
    idle(4'd10, "R11"); idle(4'd11, "R11");
    // Ignored request fields while idle (R12)
    cyc(1'b0, 3'd3, 1'b0, 4'd12, 4'd1, 1'b0, 1'b1, 1'b0, 4'd0, 16'h0, 4'd12, "R12");
    idle(4'd12, "R12");
    for (int n = 0; n < 600; n++) begin
      cyc(1'($urandom), 3'($urandom), 1'($urandom), 4'($urandom), 4'($urandom),
          1'($urandom), 1'($urandom % 4 == 0), 1'($urandom % 3 == 0), 4'($urandom),
          16'($urandom), 4'($urandom), "R10");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule